// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block is the digital half of a supply supervisor. Analog comparators outside it report four conditions as single-bit flags: the main supply is below the reset threshold, the main supply is below the backup battery, the main supply is close to the threshold, and a separate monitored voltage is below its reference. An active-low manual-reset pin is also sampled. From these the block makes four outputs:

- an active-low system reset whose release is stretched,
- a flag that selects the battery as the output supply,
- an early-warning low-line output,
- an uncommitted power-fail output.

Reset has two sources, the supply-low flag and the manual-reset pin. Each source has its own release stretcher, and the reset output is asserted while either stretcher is active. Durations are counted in ticks of a clock-enable input. The stretch length is `STRETCH_MS * TICKS_PER_MS` ticks (200 ms by default).

Top module: `supply_supervisor`

## Requirements
- R1: While `supply_low` is 1, `sys_rst_n` is 0 from the cycle after it is sampled.
- R2: After `supply_low` returns to 0, `sys_rst_n` stays 0 until the stretcher has counted `STRETCH_MS*TICKS_PER_MS` cycles with `tick_en` high. It goes to 1 on the clock edge that samples the last of those ticks.
- R3: While `man_rst_n` is 0, `sys_rst_n` is 0. After `man_rst_n` returns to 1, the same full stretch applies before release.
- R4: A new assertion from either source during a running stretch restarts that source's count from zero.
- R5: `batt_on` becomes 1 (battery selected) when `supply_low` and `supply_below_batt` are both 1. It becomes 0 (main supply selected) when both are 0. Either change takes effect one cycle after sampling.
- R6: When `supply_low` and `supply_below_batt` differ, `batt_on` keeps its previous value.
- R7: `lowline_n` equals the inverse of `supply_near_low` one cycle later and has no effect on reset.
- R8: `pf_n` equals the inverse of `pf_below_ref` one cycle later and has no effect on any other output.
- R9: While `rst_n` is 0, `sys_rst_n` is 0, `batt_on` is 0, and `lowline_n` and `pf_n` are 1. Both stretchers restart from zero, so after `rst_n` rises a full stretch runs before reset releases.
- R10: Cycles with `tick_en` at 0 do not advance a stretch, and `sys_rst_n` rises only on an edge where `tick_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| tick_en | input | 1 | Time-base enable; one pulse per tick |
| supply_low | input | 1 | Main supply below reset threshold |
| supply_below_batt | input | 1 | Main supply below battery voltage |
| supply_near_low | input | 1 | Main supply within the warning margin of the threshold |
| pf_below_ref | input | 1 | Monitored voltage below its reference |
| man_rst_n | input | 1 | Active-low manual reset |
| sys_rst_n | output | 1 | Active-low stretched system reset |
| batt_on | output | 1 | 1 when the battery feeds the output supply |
| lowline_n | output | 1 | Active-low early warning |
| pf_n | output | 1 | Active-low power-fail flag |

## Verification
Every output is registered. `batt_on`, `lowline_n` and `pf_n` follow their inputs one clock edge after sampling. `sys_rst_n` falls one edge after a reset source is sampled, and rises on the edge that samples the final tick of a stretch. The bench holds a behavioural model that it updates at each rising edge using the inputs that edge sampled. It compares all four outputs at the following falling edge, so every result is checked in exactly the cycle it is due. Inputs change only after that comparison.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

    // output supply choice
    typedef enum logic {
        SEL_MAIN = 1'b0,
        SEL_BATT = 1'b1
    } supply_sel_e;

    // number of independent reset sources
    localparam int unsigned NUM_RST_SRC = 2;
    localparam int unsigned SRC_SUPPLY  = 0;
    localparam int unsigned SRC_MANUAL  = 1;

endpackage

// File: rtl/sv_release_stretch.sv
module sv_release_stretch #(
    parameter int unsigned TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic hold_i,
    output logic active_o
);
    localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } stretch_st_t;

    stretch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick_en) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/sv_path_select.sv
module sv_path_select
    import supsv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_thresh_i,
    input  logic below_batt_i,
    output logic batt_sel_o
);
    supply_sel_e sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (below_thresh_i && below_batt_i) begin
            sel_d = SEL_BATT;
        end else if (!below_thresh_i && !below_batt_i) begin
            sel_d = SEL_MAIN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_MAIN;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign batt_sel_o = (sel_q == SEL_BATT);
endmodule

// File: rtl/sv_flag_reg.sv
module sv_flag_reg #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flag_i,
    output logic [WIDTH-1:0] flag_n_o
);
    logic [WIDTH-1:0] flag_n_d, flag_n_q;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            flag_n_d[i] = ~flag_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_n_q <= '1;
        end else begin
            flag_n_q <= flag_n_d;
        end
    end

    assign flag_n_o = flag_n_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import supsv_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1000,
    parameter int unsigned STRETCH_MS   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic supply_low,
    input  logic supply_below_batt,
    input  logic supply_near_low,
    input  logic pf_below_ref,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic batt_on,
    output logic lowline_n,
    output logic pf_n
);
    localparam int unsigned STRETCH_TICKS = TICKS_PER_MS * STRETCH_MS;

    logic [NUM_RST_SRC-1:0] src_hold;
    logic [NUM_RST_SRC-1:0] src_active;
    logic [1:0]             flags_n;

    assign src_hold[SRC_SUPPLY] = supply_low;
    assign src_hold[SRC_MANUAL] = ~man_rst_n;

    for (genvar g = 0; g < NUM_RST_SRC; g++) begin : g_src
        sv_release_stretch #(
            .TICKS (STRETCH_TICKS)
        ) u_stretch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .hold_i   (src_hold[g]),
            .active_o (src_active[g])
        );
    end

    assign sys_rst_n = ~|src_active;

    sv_path_select u_path (
        .clk            (clk),
        .rst_n          (rst_n),
        .below_thresh_i (supply_low),
        .below_batt_i   (supply_below_batt),
        .batt_sel_o     (batt_on)
    );

    sv_flag_reg #(
        .WIDTH (2)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   ({pf_below_ref, supply_near_low}),
        .flag_n_o (flags_n)
    );

    assign lowline_n = flags_n[0];
    assign pf_n      = flags_n[1];
endmodule

// File: rtl/supply_supervisor_checker.sv
module supply_supervisor_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic supply_low,
    input logic supply_below_batt,
    input logic supply_near_low,
    input logic pf_below_ref,
    input logic man_rst_n,
    input logic sys_rst_n,
    input logic batt_on,
    input logic lowline_n,
    input logic pf_n
);
    AST_SUPPLY_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !sys_rst_n); // R1

    AST_MANUAL_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !man_rst_n |=> !sys_rst_n); // R3

    AST_RELEASE_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (!$past(supply_low) && $past(man_rst_n))); // R2

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(tick_en)); // R10

    AST_BATT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low && supply_below_batt) |=> batt_on); // R5

    AST_MAIN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_low && !supply_below_batt) |=> !batt_on); // R5

    AST_MIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low != supply_below_batt) |=> $stable(batt_on)); // R6

    AST_LOWLINE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        supply_near_low |=> !lowline_n); // R7

    AST_PFAIL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pf_below_ref |=> !pf_n); // R8
endmodule

bind supply_supervisor supply_supervisor_checker u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .tick_en           (tick_en),
    .supply_low        (supply_low),
    .supply_below_batt (supply_below_batt),
    .supply_near_low   (supply_near_low),
    .pf_below_ref      (pf_below_ref),
    .man_rst_n         (man_rst_n),
    .sys_rst_n         (sys_rst_n),
    .batt_on           (batt_on),
    .lowline_n         (lowline_n),
    .pf_n              (pf_n)
);

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
    localparam int TPMS    = 2;
    localparam int SMS     = 200;
    localparam int STRETCH = TPMS * SMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic supply_low = 1'b1;
    logic supply_below_batt = 1'b1;
    logic supply_near_low = 1'b1;
    logic pf_below_ref = 1'b0;
    logic man_rst_n = 1'b1;
    logic sys_rst_n, batt_on, lowline_n, pf_n;

    always #2.5 clk = ~clk;

    supply_supervisor #(.TICKS_PER_MS(TPMS), .STRETCH_MS(SMS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_low(supply_low),
        .supply_below_batt(supply_below_batt), .supply_near_low(supply_near_low),
        .pf_below_ref(pf_below_ref), .man_rst_n(man_rst_n), .sys_rst_n(sys_rst_n),
        .batt_on(batt_on), .lowline_n(lowline_n), .pf_n(pf_n));

    int checks = 0;
    int fails  = 0;
    int tick_mode = 2;      // 0 none, 1 every cycle, 2 alternate
    int tick_phase = 0;
    string cur_req = "R9";

    // behavioural reference state
    int  m_cnt[2];
    bit  m_act[2];
    bit  m_sel, m_ll_n, m_pf_n;

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit hold[2];
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin m_act[i] = 1; m_cnt[i] = 0; end
            m_sel = 0; m_ll_n = 1; m_pf_n = 1;
            return;
        end
        hold[0] = supply_low;
        hold[1] = !man_rst_n;
        for (int i = 0; i < 2; i++) begin
            if (hold[i]) begin
                m_act[i] = 1; m_cnt[i] = 0;
            end else if (m_act[i] && tick_en) begin
                m_cnt[i]++;
                if (m_cnt[i] == STRETCH) begin m_act[i] = 0; m_cnt[i] = 0; end
            end
        end
        if (supply_low && supply_below_batt) m_sel = 1;
        else if (!supply_low && !supply_below_batt) m_sel = 0;
        m_ll_n = !supply_near_low;
        m_pf_n = !pf_below_ref;
    endtask

    task automatic compare_all();
        check(cur_req, sys_rst_n, !(m_act[0] || m_act[1]), "sys_rst_n");
        check((supply_low != supply_below_batt) ? "R6" : "R5", batt_on, m_sel, "batt_on");
        check("R7", lowline_n, m_ll_n, "lowline_n");
        check("R8", pf_n, m_pf_n, "pf_n");
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_update();
            @(negedge clk);
            compare_all();
            tick_phase++;
            case (tick_mode)
                0: tick_en = 1'b0;
                1: tick_en = 1'b1;
                default: tick_en = tick_phase[0];
            endcase
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_act[i] = 1; m_cnt[i] = 0; end
        m_sel = 0; m_ll_n = 1; m_pf_n = 1;
        @(negedge clk);
        // R9: state while logic reset is held
        cyc(4);
        check("R9", sys_rst_n, 1'b0, "sys_rst_n in reset");
        check("R9", batt_on, 1'b0, "batt_on in reset");
        rst_n = 1'b1;
        cur_req = "R1";
        cyc(3);
        check("R5", batt_on, 1'b1, "battery selected");
        check("R1", sys_rst_n, 1'b0, "reset while supply low");
        // supply recovers; stretch with alternate ticks
        supply_low = 0; supply_below_batt = 0; supply_near_low = 0;
        cur_req = "R2";
        cyc(2 * STRETCH - 6);
        check("R2", sys_rst_n, 1'b0, "still stretching");
        cyc(10);
        check("R2", sys_rst_n, 1'b1, "released after stretch");
        check("R5", batt_on, 1'b0, "main selected");
        // mixed: below threshold but above battery
        supply_low = 1; cur_req = "R1";
        cyc(5);
        check("R6", batt_on, 1'b0, "held main on mixed");
        check("R1", sys_rst_n, 1'b0, "reset on dip");
        supply_low = 0; cur_req = "R4";
        cyc(300);
        man_rst_n = 0; cyc(1); man_rst_n = 1;  // restart via other source
        cyc(300);
        supply_low = 1; cyc(1); supply_low = 0; // restart same source
        cyc(2 * STRETCH - 20);
        check("R4", sys_rst_n, 1'b0, "restart extends stretch");
        cyc(40);
        check("R4", sys_rst_n, 1'b1, "released after restart");
        // manual reset held
        cur_req = "R3";
        man_rst_n = 0; cyc(50);
        check("R3", sys_rst_n, 1'b0, "manual hold");
        man_rst_n = 1; tick_mode = 1;
        cyc(STRETCH + 5);
        check("R3", sys_rst_n, 1'b1, "manual release");
        // comparator flags do not touch reset
        cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            supply_near_low = i[0]; pf_below_ref = i[1] ^ i[2];
            cyc(1);
        end
        check("R7", sys_rst_n, 1'b1, "lowline no reset effect");
        check("R8", batt_on, 1'b0, "pfail no select effect");
        supply_near_low = 0; pf_below_ref = 0;
        // battery then mixed opposite way
        cur_req = "R6";
        supply_low = 1; supply_below_batt = 1; cyc(3);
        check("R5", batt_on, 1'b1, "battery select");
        supply_low = 0; cyc(20);
        check("R6", batt_on, 1'b1, "held battery on mixed");
        supply_below_batt = 0; cyc(2);
        check("R5", batt_on, 1'b0, "back to main");
        // no ticks: stretch frozen
        cur_req = "R10";
        tick_mode = 0;
        cyc(3 * STRETCH);
        check("R10", sys_rst_n, 1'b0, "no release without ticks");
        tick_mode = 1;
        cyc(STRETCH + 3);
        check("R10", sys_rst_n, 1'b1, "release once ticks resume");
        // logic reset mid run
        cur_req = "R9";
        supply_near_low = 1; pf_below_ref = 1;
        cyc(2);
        rst_n = 0; cyc(3);
        check("R9", lowline_n, 1'b1, "lowline idle in reset");
        check("R9", pf_n, 1'b1, "pf idle in reset");
        rst_n = 1; supply_near_low = 0; pf_below_ref = 0;
        cyc(STRETCH - 3);
        check("R9", sys_rst_n, 1'b0, "stretch after logic reset");
        cyc(6);
        check("R9", sys_rst_n, 1'b1, "released after logic reset");
        summary();
        $finish;
    end
endmodule